// File: doc/BRIEF.md
# Pipelined Synchronous Burst SRAM

This block is a synthesizable model of a synchronous static memory whose inputs and read outputs are both registered. The array holds a parameterized number of 32-bit words, each split into four byte lanes. The block samples every control and data input on the rising clock edge. The only exceptions are the output enable and the sleep input, which act at once.

An access starts on an edge where either of two active-low start strobes is low. The edge that starts an access also loads a new address and a new chip-select decision. On later edges a 2-bit internal counter supplies the next words of a four-word burst. The counter steps when the advance input is low and holds when it is high.

Writes complete on the edge where their controls are sampled. A global write covers the whole word, and a master enable qualifies the four per-lane enables. When an edge carries no write lane, the block treats it as a read. The word read is registered once more before it reaches the output, which gives a 3-1-1-1 burst.

Top module: `sync_burst_sram`

## Requirements
- R1: While reset is low, and after reset until a read reaches the output, `q` is all high-impedance and `q_en` is 0.
- R2: On an edge where `strobe_cpu_n` or `strobe_ctl_n` is low, the block loads `addr` as the burst base and clears the burst count. The access is selected only if `cs_n`=0, `cs_hi`=1 and `cs_lo_n`=0 on that same edge.
- R3: A read sampled on edge k shows its word on `q`, with `q_en`=1, just after edge k+1. Each later read edge of a burst delivers one more word per clock.
- R4: On an edge with both strobes high and `step_n` low, the 2-bit count increments. The access address keeps the upper address bits of the base, and its low two bits are (base[1:0] + count) mod 4.
- R5: On an edge with both strobes high and `step_n` high, the access repeats at the current burst address.
- R6: With `all_we_n`=1 and `lane_master_n`=0, each lane i whose `lane_we_n[i]`=0 receives `wdata[8i+7:8i]`. The other lanes keep their contents.
- R7: With `all_we_n`=0, all four lanes are written, whatever the values of `lane_master_n` and `lane_we_n`.
- R8: When no lane is enabled for writing, the edge is a read. This covers `lane_master_n`=1, and also `lane_master_n`=0 with `lane_we_n`=4'hF.
- R9: A write access never drives the output: after edge k+1, `q_en` is 0 for a write sampled on edge k.
- R10: A start edge with any chip enable inactive deselects the block. After the next edge the output is high-impedance, and no writes occur until an edge starts a selected access.
- R11: While `oe_n` is 1, `q` is high-impedance and `q_en` is 0 at once, without waiting for a clock.
- R12: While `sleep` is 1, the output is high-impedance at once. Edges sampled during sleep neither read nor write. The burst state and the array contents are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset of the control state |
| addr | input | ADDR_W | Word address, loaded on a start edge |
| strobe_cpu_n | input | 1 | First start strobe, active low |
| strobe_ctl_n | input | 1 | Second start strobe, active low |
| step_n | input | 1 | Burst advance, active low |
| cs_n | input | 1 | Active-low chip enable |
| cs_hi | input | 1 | Active-high depth-expansion enable |
| cs_lo_n | input | 1 | Active-low depth-expansion enable |
| all_we_n | input | 1 | Global write of all four lanes, active low |
| lane_master_n | input | 1 | Master enable for the per-lane writes, active low |
| lane_we_n | input | 4 | Per-lane write enables, active low; bit i selects lane i |
| wdata | input | 32 | Write data |
| oe_n | input | 1 | Asynchronous output enable, active low |
| sleep | input | 1 | Asynchronous sleep request |
| q | output | 32 | Read data; high-impedance when the output is not driven |
| q_en | output | 1 | High when `q` is driven |

## Verification
The assertions assume that `sleep`, `oe_n` and every sampled input are known and steady around each rising edge. They also assume that reset is applied before the first access, so that looking two edges back never reaches state from before reset. The stimulus changes all inputs only on the falling edge. The exception is the output enable and sleep, which it toggles in mid-cycle well clear of either edge. It holds reset for several cycles before any strobe.

// File: rtl/sbs_pkg.sv
`timescale 1ns/1ps
package sbs_pkg;
    localparam int LANES  = 4;
    localparam int LANE_W = 8;
    localparam int WORD_W = LANES * LANE_W;

    typedef logic [LANES-1:0]  lane_mask_t;
    typedef logic [WORD_W-1:0] word_t;

    typedef struct packed {
        word_t word;
        logic  drive;
    } out_reg_t;
endpackage

// File: rtl/sbs_lane_decode.sv
`timescale 1ns/1ps
module sbs_lane_decode
    import sbs_pkg::*;
(
    input  logic       all_we_n,
    input  logic       lane_master_n,
    input  lane_mask_t lane_we_n,
    output lane_mask_t lanes
);
    always_comb begin
        if (!all_we_n) begin
            lanes = '1;
        end else if (!lane_master_n) begin
            lanes = ~lane_we_n;
        end else begin
            lanes = '0;
        end
    end
endmodule

// File: rtl/sbs_array.sv
`timescale 1ns/1ps
module sbs_array
    import sbs_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  lane_mask_t        wr_mask,
    input  logic [ADDR_W-1:0] wr_addr,
    input  word_t             wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output word_t             rd_data
);
    localparam int DEPTH = 1 << ADDR_W;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] cells [DEPTH];

        always_ff @(posedge clk) begin
            if (wr_mask[g]) begin
                cells[wr_addr] <= wr_data[g*LANE_W +: LANE_W];
            end
        end

        assign rd_data[g*LANE_W +: LANE_W] = cells[rd_addr];
    end
endmodule

// File: rtl/sbs_burst_ctrl.sv
`timescale 1ns/1ps
module sbs_burst_ctrl
    import sbs_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              start,
    input  logic              step,
    input  logic              sel_ok,
    input  logic              hold_off,
    input  lane_mask_t        lanes,
    output logic [ADDR_W-1:0] eff_addr,
    output logic              eff_active,
    output logic [ADDR_W-1:0] acc_addr,
    output logic              acc_read,
    output logic [1:0]        burst_cnt
);
    localparam int HI_W = ADDR_W - 2;

    typedef struct packed {
        logic [ADDR_W-1:0] base;
        logic [1:0]        cnt;
        logic              sel;
        logic [ADDR_W-1:0] acc_addr;
        logic              acc_rd;
    } ctrl_t;

    ctrl_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        eff_addr   = st_q.acc_addr;
        eff_active = 1'b0;
        if (hold_off) begin
            st_d.acc_rd = 1'b0;
        end else begin
            if (start) begin
                st_d.base = addr;
                st_d.cnt  = 2'd0;
                st_d.sel  = sel_ok;
            end else if (step) begin
                st_d.cnt  = st_q.cnt + 2'd1;
            end
            eff_addr      = {st_d.base[ADDR_W-1 -: HI_W], 2'(st_d.base[1:0] + st_d.cnt)};
            eff_active    = st_d.sel;
            st_d.acc_addr = eff_addr;
            st_d.acc_rd   = st_d.sel && (lanes == '0);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign acc_addr  = st_q.acc_addr;
    assign acc_read  = st_q.acc_rd;
    assign burst_cnt = st_q.cnt;
endmodule

// File: rtl/sync_burst_sram.sv
`timescale 1ns/1ps
module sync_burst_sram
    import sbs_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              strobe_cpu_n,
    input  logic              strobe_ctl_n,
    input  logic              step_n,
    input  logic              cs_n,
    input  logic              cs_hi,
    input  logic              cs_lo_n,
    input  logic              all_we_n,
    input  logic              lane_master_n,
    input  logic [3:0]        lane_we_n,
    input  logic [31:0]       wdata,
    input  logic              oe_n,
    input  logic              sleep,
    output logic [31:0]       q,
    output logic              q_en
);
    lane_mask_t        lanes;
    lane_mask_t        wr_mask;
    logic [ADDR_W-1:0] eff_addr;
    logic              eff_active;
    logic [ADDR_W-1:0] acc_addr;
    logic              acc_read;
    logic [1:0]        burst_cnt;
    word_t             rd_data;
    out_reg_t          out_d, out_q;
    logic              out_drive;

    sbs_lane_decode u_decode (
        .all_we_n      (all_we_n),
        .lane_master_n (lane_master_n),
        .lane_we_n     (lane_we_n),
        .lanes         (lanes)
    );

    sbs_burst_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .addr       (addr),
        .start      (!strobe_cpu_n || !strobe_ctl_n),
        .step       (!step_n),
        .sel_ok     (!cs_n && cs_hi && !cs_lo_n),
        .hold_off   (sleep),
        .lanes      (lanes),
        .eff_addr   (eff_addr),
        .eff_active (eff_active),
        .acc_addr   (acc_addr),
        .acc_read   (acc_read),
        .burst_cnt  (burst_cnt)
    );

    assign wr_mask = eff_active ? lanes : '0;

    sbs_array #(.ADDR_W(ADDR_W)) u_array (
        .clk     (clk),
        .wr_mask (wr_mask),
        .wr_addr (eff_addr),
        .wr_data (wdata),
        .rd_addr (acc_addr),
        .rd_data (rd_data)
    );

    always_comb begin
        out_d       = out_q;
        out_d.drive = acc_read;
        if (acc_read) begin
            out_d.word = rd_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign out_drive = out_q.drive;
    assign q_en      = out_drive && !oe_n && !sleep;
    assign q         = q_en ? out_q.word : 'z;
endmodule

// File: rtl/sbs_checker.sv
`timescale 1ns/1ps
module sbs_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       strobe_cpu_n,
    input logic       strobe_ctl_n,
    input logic       step_n,
    input logic       cs_n,
    input logic       cs_hi,
    input logic       cs_lo_n,
    input logic       all_we_n,
    input logic       lane_master_n,
    input logic [3:0] lane_we_n,
    input logic       oe_n,
    input logic       sleep,
    input logic       q_en,
    input logic       out_drive,
    input logic [1:0] burst_cnt
);
    logic any_start;
    logic chip_on;
    logic any_lane;

    assign any_start = !strobe_cpu_n || !strobe_ctl_n;
    assign chip_on   = !cs_n && cs_hi && !cs_lo_n;
    assign any_lane  = !all_we_n || (!lane_master_n && (lane_we_n != 4'hF));

    // R11
    a_r11_oe_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        oe_n |-> !q_en);

    // R12
    a_r12_sleep_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        sleep |-> !q_en);

    a_r12_sleep_no_read: assert property (@(posedge clk) disable iff (!rst_n)
        $past(sleep, 2) |-> !out_drive);

    // R10
    a_r10_deselect_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        $past(any_start && !chip_on && !sleep, 2) |-> !out_drive);

    // R9
    a_r9_write_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        $past(any_lane && !sleep, 2) |-> !out_drive);

    // R2
    a_r2_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (any_start && !sleep) |=> (burst_cnt == 2'd0));

    // R4
    a_r4_step_counts: assert property (@(posedge clk) disable iff (!rst_n)
        (!any_start && !step_n && !sleep) |=> (burst_cnt == 2'($past(burst_cnt) + 2'd1)));

    // R5
    a_r5_hold_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        (!any_start && step_n) |=> $stable(burst_cnt));
endmodule

bind sync_burst_sram sbs_checker u_sbs_checker (
    .clk           (clk),
    .rst_n         (rst_n),
    .strobe_cpu_n  (strobe_cpu_n),
    .strobe_ctl_n  (strobe_ctl_n),
    .step_n        (step_n),
    .cs_n          (cs_n),
    .cs_hi         (cs_hi),
    .cs_lo_n       (cs_lo_n),
    .all_we_n      (all_we_n),
    .lane_master_n (lane_master_n),
    .lane_we_n     (lane_we_n),
    .oe_n          (oe_n),
    .sleep         (sleep),
    .q_en          (q_en),
    .out_drive     (out_drive),
    .burst_cnt     (burst_cnt)
);

// File: tb/sync_burst_sram_tb_top.sv
`timescale 1ns/1ps
module sync_burst_sram_tb_top;
    localparam int AW    = 6;
    localparam int WORDS = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] addr = '0;
    logic          strobe_cpu_n = 1'b1;
    logic          strobe_ctl_n = 1'b1;
    logic          step_n = 1'b1;
    logic          cs_n = 1'b0;
    logic          cs_hi = 1'b1;
    logic          cs_lo_n = 1'b0;
    logic          all_we_n = 1'b1;
    logic          lane_master_n = 1'b1;
    logic [3:0]    lane_we_n = 4'hF;
    logic [31:0]   wdata = '0;
    logic          oe_n = 1'b0;
    logic          sleep = 1'b0;
    wire  [31:0]   q;
    wire           q_en;

    int    checks = 0;
    int    errors = 0;
    bit    done = 0;
    string req = "R1";

    // behavioural reference state
    logic [31:0] m_mem [WORDS];
    int          m_base = 0;
    int          m_cnt = 0;
    bit          m_sel = 0;
    bit          m_acc_rd = 0;
    int          m_acc_addr = 0;
    logic [31:0] m_word = 'x;
    bit          m_drive = 0;

    always #2 clk = ~clk;

    sync_burst_sram #(.ADDR_W(AW)) dut_i (
        .clk(clk), .rst_n(rst_n), .addr(addr),
        .strobe_cpu_n(strobe_cpu_n), .strobe_ctl_n(strobe_ctl_n), .step_n(step_n),
        .cs_n(cs_n), .cs_hi(cs_hi), .cs_lo_n(cs_lo_n),
        .all_we_n(all_we_n), .lane_master_n(lane_master_n), .lane_we_n(lane_we_n),
        .wdata(wdata), .oe_n(oe_n), .sleep(sleep), .q(q), .q_en(q_en)
    );

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_base = 0; m_cnt = 0; m_sel = 0; m_acc_rd = 0; m_drive = 0;
        end else begin
            int ea;
            logic [3:0] mask;
            if (m_acc_rd) m_word = m_mem[m_acc_addr];
            m_drive = m_acc_rd;
            if (sleep) begin
                m_acc_rd = 0;
            end else begin
                if (!strobe_cpu_n || !strobe_ctl_n) begin
                    m_base = int'(addr);
                    m_cnt  = 0;
                    m_sel  = !cs_n && cs_hi && !cs_lo_n;
                end else if (!step_n) begin
                    m_cnt = (m_cnt + 1) % 4;
                end
                ea = (m_base / 4) * 4 + ((m_base % 4) + m_cnt) % 4;
                if (!all_we_n) mask = 4'hF;
                else if (!lane_master_n) mask = ~lane_we_n;
                else mask = 4'h0;
                if (m_sel) begin
                    for (int i = 0; i < 4; i++) begin
                        if (mask[i]) m_mem[ea][i*8 +: 8] = wdata[i*8 +: 8];
                    end
                end
                m_acc_rd   = m_sel && (mask == 4'h0);
                m_acc_addr = ea;
            end
        end
    end

    task automatic compare();
        logic [31:0] exp_q;
        logic        exp_en;
        exp_en = m_drive && !oe_n && !sleep;
        exp_q  = exp_en ? m_word : 32'hz;
        checks++;
        if (q !== exp_q || q_en !== exp_en) begin
            errors++;
            $display("FAIL %s: q=%h q_en=%b expected q=%h q_en=%b", req, q, q_en, exp_q, exp_en);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
        compare();
    endtask

    task automatic idle_in();
        strobe_cpu_n = 1'b1; strobe_ctl_n = 1'b1; step_n = 1'b1;
        all_we_n = 1'b1; lane_master_n = 1'b1; lane_we_n = 4'hF;
    endtask

    task automatic begin_acc(input int a, input bit use_cpu);
        idle_in();
        addr = AW'(a);
        if (use_cpu) strobe_cpu_n = 1'b0;
        else strobe_ctl_n = 1'b0;
    endtask

    task automatic summary();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: q=%h q_en=%b expected q=%h q_en=%b", q, q_en, 32'h0, 1'b0);
            summary();
            $finish;
        end
    end

    initial begin
        // R1 reset state
        req = "R1";
        repeat (3) @(negedge clk);
        compare();
        rst_n = 1'b1;
        tick();

        // R7 fill every word with a global write
        req = "R7";
        for (int i = 0; i < WORDS; i++) begin
            begin_acc(i, 0);
            all_we_n = 1'b0; lane_master_n = 1'b1; lane_we_n = 4'hF;
            wdata = 32'h5A00_0000 ^ (i * 32'h0103_0507);
            tick();
        end
        idle_in(); tick(); tick();

        // R3 single read latency
        req = "R3";
        begin_acc(5, 1); tick();
        idle_in(); step_n = 1'b0; tick(); tick();
        idle_in(); tick();

        // R2 second strobe, and start edge with strobe ignoring count
        req = "R2";
        begin_acc(9, 0); tick();
        idle_in(); tick(); tick();
        begin_acc(17, 1); tick(); tick();

        // R4 burst wrap from a mid-block base
        req = "R4";
        begin_acc(6, 1); tick();
        idle_in(); step_n = 1'b0;
        tick(); tick(); tick(); tick();
        idle_in(); tick();

        // R5 hold repeats the same word
        req = "R5";
        begin_acc(13, 0); tick();
        idle_in(); tick(); tick(); tick();

        // R6 partial lane write then read back
        req = "R6";
        begin_acc(20, 0);
        lane_master_n = 1'b0; lane_we_n = 4'b1010; wdata = 32'h1122_3344;
        tick();
        idle_in(); tick();
        begin_acc(20, 1); tick();
        idle_in(); tick(); tick();

        // R8 no lane enabled reads
        req = "R8";
        begin_acc(21, 0);
        lane_master_n = 1'b0; lane_we_n = 4'hF; wdata = 32'hDEAD_BEEF;
        tick(); tick(); tick();
        begin_acc(22, 0);
        lane_master_n = 1'b1; lane_we_n = 4'h0; wdata = 32'hCAFE_F00D;
        tick(); tick(); tick();
        idle_in(); tick();

        // R7 global write overrides lane enables
        req = "R7";
        begin_acc(23, 1);
        all_we_n = 1'b0; lane_master_n = 1'b0; lane_we_n = 4'hF; wdata = 32'h7777_8888;
        tick();
        idle_in(); tick(); tick();

        // R9 write burst keeps output quiet, then read it back
        req = "R9";
        begin_acc(24, 0);
        all_we_n = 1'b0; wdata = 32'hA1A1_0000;
        tick();
        step_n = 1'b0;
        for (int k = 1; k < 4; k++) begin
            wdata = 32'hA1A1_0000 + k;
            tick();
        end
        idle_in(); tick();
        begin_acc(24, 1); tick();
        idle_in(); step_n = 1'b0;
        tick(); tick(); tick(); tick();
        idle_in(); tick();

        // R10 deselect through each chip enable
        req = "R10";
        for (int k = 0; k < 3; k++) begin
            begin_acc(30, 0);
            cs_n = (k == 0); cs_hi = (k != 1); cs_lo_n = (k == 2);
            all_we_n = 1'b0; wdata = 32'hBAD0_0000 + k;
            tick();
            step_n = 1'b0; tick(); tick();
            cs_n = 1'b0; cs_hi = 1'b1; cs_lo_n = 1'b0;
            idle_in(); tick();
        end
        begin_acc(30, 1); tick();
        idle_in(); tick(); tick();

        // R11 asynchronous output enable
        req = "R11";
        begin_acc(12, 0); tick();
        idle_in(); tick();
        #1 oe_n = 1'b1;
        #0.5 compare();
        tick();
        #1 oe_n = 1'b0;
        #0.5 compare();
        tick();

        // R12 sleep blocks output and accesses, keeps state
        req = "R12";
        begin_acc(7, 1); tick();
        idle_in(); tick();
        #1 sleep = 1'b1;
        #0.5 compare();
        @(negedge clk);
        begin_acc(7, 0);
        all_we_n = 1'b0; wdata = 32'hFFFF_0000;
        tick(); tick();
        idle_in(); tick();
        sleep = 1'b0;
        tick(); tick();
        begin_acc(7, 1); tick();
        idle_in(); tick(); tick();

        done = 1;
        summary();
        $finish;
    end
endmodule